// File: doc/BRIEF.md
# Video Sync Timing Generator

This block paces the digital video output of an image sensor. On every clock where the pixel-rate enable is high it emits one output sample: a row sync, a frame sync, a data-valid qualifier and a pixel word. Each row starts with an optional run of dummy words, then the real pixels taken from the pixel input, then a fixed-length horizontal gap. After the final row of a frame comes a fixed-length vertical gap, and the next frame starts.

Each sync runs in one of two styles. In level style it frames the active data. In pulse style it marks the end of a row or of a frame with a pulse of at least four ticks. The frame sync has a third style that shows whether the current field is odd or even. Both syncs have a programmable polarity. An output-phase option moves every pin change to the falling clock edge that follows the tick. Row length, row count and dummy count are sampled only at frame boundaries, so a frame never mixes two geometries.

Top module: `vid_sync_gen`

## Requirements
- R1: While reset is asserted, and until the first enabled tick after reset, hsync is 0, vsync is 1, data_valid is 0 and data_out is 0. The first enabled tick after reset is an idle sample with both syncs inactive. The first frame starts on the tick after it.
- R2: With hs_pulse=0 (level style), hsync is active for exactly dummy+row_len consecutive samples in each row, and those are exactly the samples with data_valid high. After them comes a gap of HS_GAP samples (default 4) with hsync inactive.
- R3: With vs_mode=0 or vs_mode=3 (level style), vsync is active from the first sample of row 0 through the last pixel of the final row. It is inactive during the final row's horizontal gap and during the VS_GAP-sample vertical gap (default 4).
- R4: With hs_pulse=1, hsync is active for the HS_GAP samples (at least 4) that follow the last pixel of every row, and data_valid is low throughout that pulse.
- R5: With vs_mode=1, vsync is active for the VS_GAP samples (at least 4) that follow the final row's horizontal gap, and inactive everywhere else.
- R6: The pin levels are hsync = active XOR hs_inv and vsync = NOT active XOR vs_inv. With both inversion bits at 0, hsync is active high and vsync is active low.
- R7: With vs_mode=2 (field style), vsync is active for every sample of odd frames and inactive for every sample of even frames. The first frame after reset is odd. The level changes on the first sample of a frame.
- R8: In every row, the first cfg_dummy (0 to 15) valid samples carry data_out=0. Each real pixel sample carries the pix_in value present at its tick. With cfg_dummy=0, the first real pixel appears on the same sample as the level-style hsync activation.
- R9: cfg_row_len, cfg_row_cnt and cfg_dummy are captured only on the tick that starts a frame. A change made at any other time has no effect until the next frame.
- R10: On clocks where pix_en is low the outputs hold and the raster does not advance. Each enabled tick produces exactly one sample.
- R11: With launch_fall=0, outputs change just after the rising clock edge of a tick. With launch_fall=1, the same values appear at the following falling edge instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-rate tick enable |
| pix_in | input | DATA_W | Pixel word from the readout path |
| cfg_row_len | input | COL_W | Real pixels per row (nonzero) |
| cfg_row_cnt | input | ROW_W | Rows per frame (nonzero) |
| cfg_dummy | input | DUM_W | Dummy words at the start of each row |
| hs_pulse | input | 1 | Row sync style: 0 level, 1 end-of-row pulse |
| vs_mode | input | 2 | Frame sync style: 0/3 level, 1 end-of-frame pulse, 2 field |
| hs_inv | input | 1 | Invert row sync polarity |
| vs_inv | input | 1 | Invert frame sync polarity |
| launch_fall | input | 1 | Launch outputs on the falling edge |
| hsync | output | 1 | Row sync |
| vsync | output | 1 | Frame sync |
| data_valid | output | 1 | Data qualifier |
| data_out | output | DATA_W | Pixel output bus |

## Verification
The bench targets several corner cases.
- A row with zero dummies: if the design shifts by one here, the first pixel lands a tick after the row sync edge.
- The final row's gap in level style: a design that gets this wrong holds vsync for one gap too long.
- The pulse-style syncs: a wrong design lets data_valid overlap the pulse or shortens it below four ticks.
- Field style: a wrong design flips vsync a sample early, during the vertical gap.

It also changes geometry in the middle of a frame, where a design without shadow registers would mix row lengths, and it runs with a sparse pixel enable and with falling-edge launch, which catch a raster that advances on idle clocks or a launch stage that lags by a whole cycle.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
   typedef enum logic [1:0] {SEG_IDLE, SEG_ACT, SEG_HGAP, SEG_VGAP} seg_e;
   localparam logic [1:0] VS_LEVEL = 2'd0;
   localparam logic [1:0] VS_PULSE = 2'd1;
   localparam logic [1:0] VS_FIELD = 2'd2;
endpackage

// File: rtl/vsg_raster.sv
module vsg_raster
   import vsg_pkg::*;
#(
   parameter int COL_W    = 10,
   parameter int ROW_W    = 9,
   parameter int DUM_W    = 4,
   parameter int HS_GAP   = 4,
   parameter int VS_GAP   = 4,
   parameter int DEF_LEN  = 648,
   parameter int DEF_ROWS = 488
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_en,
   input  logic [COL_W-1:0] cfg_len,
   input  logic [ROW_W-1:0] cfg_rows,
   input  logic [DUM_W-1:0] cfg_dum,
   output seg_e             seg_o,
   output logic             dummy_o,
   output logic             last_row_o,
   output logic             field_o
);
   localparam int CNT_W = COL_W + 1;
   localparam logic [CNT_W-1:0] HG_LAST = CNT_W'(HS_GAP - 1);
   localparam logic [CNT_W-1:0] VG_LAST = CNT_W'(VS_GAP - 1);

   if (HS_GAP < 4) begin : g_bad_hgap
      $error("HS_GAP must be at least 4");
   end
   if (VS_GAP < 4) begin : g_bad_vgap
      $error("VS_GAP must be at least 4");
   end
   if (DUM_W >= CNT_W || HS_GAP >= (1 << CNT_W) || VS_GAP >= (1 << CNT_W)) begin : g_bad_cnt
      $error("counter too narrow for gaps or dummy count");
   end

   seg_e             seg;
   logic [CNT_W-1:0] pcnt;
   logic [ROW_W-1:0] rcnt;
   logic             field;
   logic [COL_W-1:0] sh_len;
   logic [ROW_W-1:0] sh_rows;
   logic [DUM_W-1:0] sh_dum;
   logic [CNT_W-1:0] row_last;
   logic             last_row;
   logic             frame_go;

   assign row_last = CNT_W'(sh_dum) + CNT_W'(sh_len) - CNT_W'(1);
   assign last_row = (rcnt == sh_rows - ROW_W'(1));
   assign frame_go = (seg == SEG_IDLE) || (seg == SEG_VGAP && pcnt == VG_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg     <= SEG_IDLE;
         pcnt    <= '0;
         rcnt    <= '0;
         field   <= 1'b0;
         sh_len  <= COL_W'(DEF_LEN);
         sh_rows <= ROW_W'(DEF_ROWS);
         sh_dum  <= '0;
      end else if (pix_en) begin
         if (frame_go) begin
            sh_len  <= cfg_len;
            sh_rows <= cfg_rows;
            sh_dum  <= cfg_dum;
            field   <= ~field;
            seg     <= SEG_ACT;
            pcnt    <= '0;
            rcnt    <= '0;
         end else begin
            case (seg)
               SEG_ACT: begin
                  if (pcnt == row_last) begin
                     seg  <= SEG_HGAP;
                     pcnt <= '0;
                  end else begin
                     pcnt <= pcnt + CNT_W'(1);
                  end
               end
               SEG_HGAP: begin
                  if (pcnt == HG_LAST) begin
                     pcnt <= '0;
                     if (last_row) begin
                        seg <= SEG_VGAP;
                     end else begin
                        seg  <= SEG_ACT;
                        rcnt <= rcnt + ROW_W'(1);
                     end
                  end else begin
                     pcnt <= pcnt + CNT_W'(1);
                  end
               end
               default: pcnt <= pcnt + CNT_W'(1);
            endcase
         end
      end
   end

   assign seg_o      = seg;
   assign dummy_o    = (seg == SEG_ACT) && (pcnt < CNT_W'(sh_dum));
   assign last_row_o = last_row;
   assign field_o    = field;

   // R4: the row gap never ends before its minimum length
   p_hgap_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && seg == SEG_HGAP && pcnt < HG_LAST |=> seg == SEG_HGAP);
   // R5: the frame gap never ends before its minimum length
   p_vgap_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && seg == SEG_VGAP && pcnt < VG_LAST |=> seg == SEG_VGAP);
   // R9: geometry is frozen while pixels of a row are emitted
   p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      seg == SEG_ACT |=> $stable(sh_len) && $stable(sh_rows) && $stable(sh_dum));
endmodule

// File: rtl/vsg_shaper.sv
module vsg_shaper
   import vsg_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  seg_e              seg,
   input  logic              dummy,
   input  logic              last_row,
   input  logic              field,
   input  logic              hs_pulse,
   input  logic [1:0]        vs_mode,
   input  logic              hs_inv,
   input  logic              vs_inv,
   input  logic [DATA_W-1:0] pix_in,
   output logic              hs_q,
   output logic              vs_q,
   output logic              val_q,
   output logic [DATA_W-1:0] dat_q
);
   logic act, hgap, vgap;
   logic hs_raw, vs_raw;

   assign act  = (seg == SEG_ACT);
   assign hgap = (seg == SEG_HGAP);
   assign vgap = (seg == SEG_VGAP);

   always_comb begin
      hs_raw = hs_pulse ? hgap : act;
      case (vs_mode)
         VS_PULSE: vs_raw = vgap;
         VS_FIELD: vs_raw = field;
         default:  vs_raw = act || (hgap && !last_row);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q  <= 1'b0;
         vs_q  <= 1'b1;
         val_q <= 1'b0;
         dat_q <= '0;
      end else if (pix_en) begin
         hs_q  <= hs_raw ^ hs_inv;
         vs_q  <= ~vs_raw ^ vs_inv;
         val_q <= act;
         dat_q <= (act && !dummy) ? pix_in : '0;
      end
   end

   // R10: no output moves on a clock without a tick
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable({hs_q, vs_q, val_q, dat_q}));
   // R8: dummy samples are valid and carry zero
   p_dummy_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && dummy |=> val_q && dat_q == '0);
   // R4: no valid data while the row pulse is emitted
   p_pulse_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en && hs_pulse && seg == SEG_HGAP |=> !val_q);
endmodule

// File: rtl/vsg_launch.sv
module vsg_launch #(
   parameter int             W         = 15,
   parameter logic [W-1:0]   RST_VAL   = '0,
   parameter bit             PHASE_OPT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         launch_fall,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   if (W < 1) begin : g_bad_w
      $error("launch width must be positive");
   end

   if (PHASE_OPT) begin : g_fall
      logic [W-1:0] fall_q;
      always_ff @(negedge clk or negedge rst_n) begin
         if (!rst_n) fall_q <= RST_VAL;
         else        fall_q <= d_in;
      end
      assign d_out = launch_fall ? fall_q : d_in;
   end else begin : g_rise
      assign d_out = d_in;
   end
endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen
   import vsg_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int COL_W     = 10,
   parameter int ROW_W     = 9,
   parameter int DUM_W     = 4,
   parameter int HS_GAP    = 4,
   parameter int VS_GAP    = 4,
   parameter bit PHASE_OPT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic [DATA_W-1:0] pix_in,
   input  logic [COL_W-1:0]  cfg_row_len,
   input  logic [ROW_W-1:0]  cfg_row_cnt,
   input  logic [DUM_W-1:0]  cfg_dummy,
   input  logic              hs_pulse,
   input  logic [1:0]        vs_mode,
   input  logic              hs_inv,
   input  logic              vs_inv,
   input  logic              launch_fall,
   output logic              hsync,
   output logic              vsync,
   output logic              data_valid,
   output logic [DATA_W-1:0] data_out
);
   localparam int BUN_W = DATA_W + 3;
   localparam logic [BUN_W-1:0] BUN_RST = {1'b0, 1'b1, 1'b0, {DATA_W{1'b0}}};

   seg_e              seg;
   logic              dummy, last_row, field;
   logic              hs_q, vs_q, val_q;
   logic [DATA_W-1:0] dat_q;
   logic [BUN_W-1:0]  bun_out;

   vsg_raster #(
      .COL_W(COL_W), .ROW_W(ROW_W), .DUM_W(DUM_W),
      .HS_GAP(HS_GAP), .VS_GAP(VS_GAP)
   ) raster_i (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
      .cfg_len(cfg_row_len), .cfg_rows(cfg_row_cnt), .cfg_dum(cfg_dummy),
      .seg_o(seg), .dummy_o(dummy), .last_row_o(last_row), .field_o(field)
   );

   vsg_shaper #(.DATA_W(DATA_W)) shaper_i (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
      .seg(seg), .dummy(dummy), .last_row(last_row), .field(field),
      .hs_pulse(hs_pulse), .vs_mode(vs_mode), .hs_inv(hs_inv), .vs_inv(vs_inv),
      .pix_in(pix_in),
      .hs_q(hs_q), .vs_q(vs_q), .val_q(val_q), .dat_q(dat_q)
   );

   vsg_launch #(.W(BUN_W), .RST_VAL(BUN_RST), .PHASE_OPT(PHASE_OPT)) launch_i (
      .clk(clk), .rst_n(rst_n), .launch_fall(launch_fall),
      .d_in({hs_q, vs_q, val_q, dat_q}), .d_out(bun_out)
   );

   assign {hsync, vsync, data_valid, data_out} = bun_out;
endmodule

// File: tb/vid_sync_gen_tb_top.sv
`timescale 1ns/100ps
module vid_sync_gen_tb_top;
   localparam int DW = 12, CW = 10, RW = 9, GAPH = 4, GAPV = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0, pix_en = 1'b0;
   logic [DW-1:0] pix_in = '0;
   logic [CW-1:0] cfg_row_len = 10'd6;
   logic [RW-1:0] cfg_row_cnt = 9'd3;
   logic [3:0] cfg_dummy = 4'd0;
   logic hs_pulse = 1'b0, hs_inv = 1'b0, vs_inv = 1'b0, launch_fall = 1'b0;
   logic [1:0] vs_mode = 2'd0;
   logic hsync, vsync, data_valid;
   logic [DW-1:0] data_out;

   vid_sync_gen dut_i (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pix_in(pix_in),
      .cfg_row_len(cfg_row_len), .cfg_row_cnt(cfg_row_cnt), .cfg_dummy(cfg_dummy),
      .hs_pulse(hs_pulse), .vs_mode(vs_mode), .hs_inv(hs_inv), .vs_inv(vs_inv),
      .launch_fall(launch_fall),
      .hsync(hsync), .vsync(vsync), .data_valid(data_valid), .data_out(data_out)
   );

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;
   string tag = "R1";

   // reference model: frame-local tick index
   bit m_started = 0, m_field = 0;
   int m_k = 0, m_D = 0, m_L = 648, m_R = 488;
   logic e_hs = 0, e_vs = 1, e_val = 0;
   logic [DW-1:0] e_dat = '0;
   logic p_hs = 0, p_vs = 1, p_val = 0;
   logic [DW-1:0] p_dat = '0;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int frame_ticks();
      return m_R * (m_D + m_L + GAPH) + GAPV;
   endfunction

   task automatic compute_exp();
      bit act = 0, hgap = 0, vgap = 0, dum = 0, lr = 0, hraw, vraw;
      if (m_started) begin
         int rp = m_D + m_L + GAPH;
         if (m_k < m_R * rp) begin
            int c = m_k % rp;
            act  = (c < m_D + m_L);
            dum  = (c < m_D);
            hgap = !act;
            lr   = (m_k / rp) == m_R - 1;
         end else begin
            vgap = 1;
         end
      end
      hraw = hs_pulse ? hgap : act;
      if (vs_mode == 2'd1) vraw = vgap;
      else if (vs_mode == 2'd2) vraw = m_field;
      else vraw = act || (hgap && !lr);
      e_hs  = hraw ^ hs_inv;
      e_vs  = ~vraw ^ vs_inv;
      e_val = act;
      e_dat = (act && !dum) ? pix_in : '0;
   endtask

   task automatic load_geom();
      m_D = cfg_dummy; m_L = cfg_row_len; m_R = cfg_row_cnt;
   endtask

   task automatic advance();
      if (!m_started) begin
         m_started = 1; load_geom(); m_field = ~m_field; m_k = 0;
      end else begin
         m_k++;
         if (m_k == frame_ticks()) begin
            m_k = 0; load_geom(); m_field = ~m_field;
         end
      end
   endtask

   task automatic cmp_pins(logic h, logic v, logic val, logic [DW-1:0] d);
      chk("hsync", 32'(hsync), 32'(h));
      chk("vsync", 32'(vsync), 32'(v));
      chk("data_valid", 32'(data_valid), 32'(val));
      chk("data_out", 32'(data_out), 32'(d));
   endtask

   // called at posedge+4ns; drives, waits for the edge, checks
   task automatic step(bit en, logic [DW-1:0] px);
      pix_en = en; pix_in = px;
      @(posedge clk);
      p_hs = e_hs; p_vs = e_vs; p_val = e_val; p_dat = e_dat;
      if (en) begin compute_exp(); advance(); end
      #1;
      if (launch_fall) cmp_pins(p_hs, p_vs, p_val, p_dat);   // R11 not yet launched
      else             cmp_pins(e_hs, e_vs, e_val, e_dat);
      #2.5;
      if (launch_fall) cmp_pins(e_hs, e_vs, e_val, e_dat);   // R11 after falling edge
      #0.5;
   endtask

   task automatic run(int n, int en_pct);
      for (int i = 0; i < n; i++) step(($urandom % 100) < en_pct, DW'($urandom));
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(posedge clk);
      #1;
      tag = "R1 reset";
      cmp_pins(1'b0, 1'b1, 1'b0, '0);
      @(posedge clk); #3;
      rst_n = 1'b1;
      @(posedge clk); #1;
      tag = "R1 no tick yet";
      cmp_pins(1'b0, 1'b1, 1'b0, '0);
      #3;
      tag = "R1 R2 R3 R8 level zero dummy";
      run(110, 100);
      tag = "R8 R9 dummies and mid-frame change";
      cfg_dummy = 4'd3;
      run(17, 100);
      cfg_row_len = 10'd9;  // R9: must wait for next frame
      cfg_row_cnt = 9'd2;
      run(120, 100);
      tag = "R3 code 3 level";
      vs_mode = 2'd3;
      run(60, 100);
      tag = "R4 R5 pulse";
      hs_pulse = 1'b1; vs_mode = 2'd1;
      cfg_dummy = 4'd0; cfg_row_len = 10'd5; cfg_row_cnt = 9'd3;
      run(130, 100);
      tag = "R6 polarity";
      hs_inv = 1'b1; vs_inv = 1'b1;
      run(70, 100);
      hs_pulse = 1'b0; vs_mode = 2'd0;
      run(70, 100);
      tag = "R7 field";
      hs_inv = 1'b0; vs_inv = 1'b0; vs_mode = 2'd2;
      run(150, 100);
      vs_inv = 1'b1;
      run(60, 100);
      tag = "R10 sparse enable";
      vs_inv = 1'b0; vs_mode = 2'd0; cfg_dummy = 4'd2;
      run(200, 40);
      tag = "R11 falling launch";
      launch_fall = 1'b1;
      run(120, 100);
      run(60, 60);
      launch_fall = 1'b0;
      tag = "random R2 R4 R5 R6 R7 R8 R10";
      for (int r = 0; r < 8; r++) begin
         cfg_row_len = CW'(1 + $urandom % 12);
         cfg_row_cnt = RW'(1 + $urandom % 4);
         cfg_dummy   = 4'($urandom % 16);
         hs_pulse    = 1'($urandom);
         vs_mode     = 2'($urandom);
         hs_inv      = 1'($urandom);
         vs_inv      = 1'($urandom);
         launch_fall = 1'($urandom);
         run(150, 75);
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule